// File: doc/BRIEF.md
# Clock-Ratio Sample-Rate Mode Detector

This block runs on the master clock of an audio converter port. It counts how many master-clock cycles fall between successive rising edges of the frame clock (the left/right word clock) and sorts that ratio into one of three speed classes. The ratios 512 and 768 give normal speed, 256 and 384 give double speed, and 128 and 192 give quad speed. Neighbouring filter and interface logic uses the resulting 2-bit speed code.

In automatic mode the measured class drives the speed output. In manual mode a 2-bit code chosen by the surrounding register logic drives it, and the measurement only confirms that code. A validity flag tells downstream logic when the measurement is stable and agrees with the chosen speed. The block also gates a de-emphasis request, which is honoured only while the effective speed is normal.

Top module: `rate_mode_detect`

## Requirements
- R1: During and after reset, before any measurement has completed, `speed_mode` is 2'b00, `mode_valid` is 0 and `deemph_en` is 0.
- R2: In automatic mode (`auto_sel`=1), a frame period of 512 or 768 master-clock cycles sets `speed_mode` to 2'b00 (normal).
- R3: In automatic mode, a frame period of 256 or 384 master-clock cycles sets `speed_mode` to 2'b01 (double).
- R4: In automatic mode, a frame period of 128 or 192 master-clock cycles sets `speed_mode` to 2'b10 (quad).
- R5: A period is accepted as a class only if it lies within ±`TOL_CYC` cycles (default 4) of a nominal ratio. Any other period clears `mode_valid` and leaves `speed_mode` unchanged.
- R6: `mode_valid` rises only after two consecutive closed periods fall in the same class. A period whose class differs from the previous one clears `mode_valid` and holds the last valid speed.
- R7: In manual mode (`auto_sel`=0), a legal `manual_code` (00, 01 or 10) appears on `speed_mode` one cycle after it is applied. In automatic mode, `manual_code` has no effect on either output.
- R8: In manual mode, the code 2'b11 forces `mode_valid` to 0 and holds `speed_mode` at its previous value. `speed_mode` never shows 2'b11.
- R9: In manual mode, `mode_valid` is 1 only when the measured class is stable and equals `manual_code`.
- R10: `deemph_en` equals `deemph_req` while the effective speed is normal, and it is 0 at double or quad speed.
- R11: If no frame-clock rising edge arrives for 2^`CNT_W`-1 master-clock cycles (2047 by default), `mode_valid` clears. After that, two fresh agreeing periods are needed to raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register is clocked by it |
| rst_n | input | 1 | Active-low synchronous reset |
| lrck | input | 1 | Frame clock, asynchronous to clk |
| auto_sel | input | 1 | 1: speed taken from measurement; 0: speed taken from manual_code |
| manual_code | input | 2 | Manual speed code: 00 normal, 01 double, 10 quad, 11 illegal |
| deemph_req | input | 1 | Request to apply de-emphasis |
| speed_mode | output | 2 | Effective speed: 00 normal, 01 double, 10 quad |
| mode_valid | output | 1 | Measurement stable and consistent with the effective speed |
| deemph_en | output | 1 | De-emphasis enable after speed gating |

## Verification
The bound checker watches the output relations on every cycle. It checks that de-emphasis is never enabled away from normal speed, that a legal manual code reaches the output one cycle later, that the illegal code holds the speed and clears validity, that the output code is never 2'b11, and that a saturated period counter clears validity. Classification, the tolerance window, the two-period agreement rule and recovery after a stall depend on frame-clock histories. Only the bench's period sequences can show these. Its behavioural model tracks those histories and compares against the outputs once the synchronizer and pipeline latency has elapsed.

// File: rtl/rate_pkg.sv
`timescale 1ns/1ps
package rate_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10,
      SPD_NONE   = 2'b11
   } speed_e;

   // nominal clock-per-frame ratio for window index 0..5, ascending;
   // indices 0,1 quad, 2,3 double, 4,5 normal
   function automatic int unsigned ratio_nominal(input int unsigned base, input int idx);
      int unsigned r;
      case (idx)
         0:       r = base;
         1:       r = (base * 3) / 2;
         2:       r = base * 2;
         3:       r = base * 3;
         4:       r = base * 4;
         default: r = base * 6;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rate_lrck_edge.sv
`timescale 1ns/1ps
module rate_lrck_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lrck_async,
   output logic rise_o
);
   localparam int SH_W = SYNC_STAGES + 1;

   logic [SH_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], lrck_async};
   end

   assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/rate_period_count.sv
`timescale 1ns/1ps
module rate_period_count #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   output logic             done_o,
   output logic [CNT_W-1:0] period_o,
   output logic             stall_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             started_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [CNT_W-1:0] per_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         cnt_q     <= '0;
         done_q    <= 1'b0;
         per_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (rise_i) begin
            started_q <= 1'b1;
            cnt_q     <= CNT_ONE;
            if (started_q) begin
               done_q <= 1'b1;
               per_q  <= cnt_q;
            end
         end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
         end
      end
   end

   assign done_o   = done_q;
   assign period_o = per_q;
   assign stall_o  = started_q && (cnt_q == CNT_MAX);
endmodule

// File: rtl/rate_ratio_class.sv
`timescale 1ns/1ps
module rate_ratio_class
   import rate_pkg::*;
#(
   parameter int CNT_W      = 11,
   parameter int BASE_RATIO = 128,
   parameter int TOL_CYC    = 4
) (
   input  logic [CNT_W-1:0] period_i,
   output speed_e           class_o
);
   localparam int N_WIN = 6;

   logic [N_WIN-1:0] hit;

   for (genvar gi = 0; gi < N_WIN; gi++) begin : g_win
      localparam int unsigned NOM = ratio_nominal(BASE_RATIO, gi);
      localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL_CYC);
      localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL_CYC);
      assign hit[gi] = (period_i >= LO) && (period_i <= HI);
   end

   always_comb begin
      if (|hit[5:4])      class_o = SPD_NORMAL;
      else if (|hit[3:2]) class_o = SPD_DOUBLE;
      else if (|hit[1:0]) class_o = SPD_QUAD;
      else                class_o = SPD_NONE;
   end
endmodule

// File: rtl/rate_mode_detect.sv
`timescale 1ns/1ps
module rate_mode_detect
   import rate_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int BASE_RATIO  = 128,
   parameter int TOL_CYC     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lrck,
   input  logic       auto_sel,
   input  logic [1:0] manual_code,
   input  logic       deemph_req,
   output logic [1:0] speed_mode,
   output logic       mode_valid,
   output logic       deemph_en
);
   localparam int MAX_NOM = 6 * BASE_RATIO;

   initial begin
      if (SYNC_STAGES < 2)
         $error("rate_mode_detect: SYNC_STAGES must be at least 2");
      if (4 * TOL_CYC >= BASE_RATIO)
         $error("rate_mode_detect: TOL_CYC too wide, class windows overlap");
      if ((2 ** CNT_W) - 1 <= MAX_NOM + TOL_CYC)
         $error("rate_mode_detect: CNT_W too small for the largest ratio");
   end

   logic             rise;
   logic             done;
   logic [CNT_W-1:0] period;
   logic             stall;
   speed_e           cls;

   rate_lrck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .lrck_async(lrck), .rise_o(rise)
   );

   rate_period_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rise_i(rise),
      .done_o(done), .period_o(period), .stall_o(stall)
   );

   rate_ratio_class #(.CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO), .TOL_CYC(TOL_CYC)) u_cls (
      .period_i(period), .class_o(cls)
   );

   // two-period agreement on the measured class
   speed_e last_cls_q;
   speed_e meas_mode_q;
   logic   meas_ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_cls_q  <= SPD_NONE;
         meas_mode_q <= SPD_NORMAL;
         meas_ok_q   <= 1'b0;
      end else if (stall) begin
         last_cls_q <= SPD_NONE;
         meas_ok_q  <= 1'b0;
      end else if (done) begin
         last_cls_q <= cls;
         if (cls == SPD_NONE) begin
            meas_ok_q <= 1'b0;
         end else if (cls == last_cls_q) begin
            meas_ok_q   <= 1'b1;
            meas_mode_q <= cls;
         end else begin
            meas_ok_q <= 1'b0;
         end
      end
   end

   // effective mode selection
   speed_e mode_q;
   logic   valid_q;
   logic   deemph_q;
   speed_e nxt_mode;
   logic   nxt_valid;

   always_comb begin
      nxt_mode  = mode_q;
      nxt_valid = 1'b0;
      if (auto_sel) begin
         nxt_mode  = meas_mode_q;
         nxt_valid = meas_ok_q;
      end else if (manual_code != 2'b11) begin
         nxt_mode  = speed_e'(manual_code);
         nxt_valid = meas_ok_q && (meas_mode_q == speed_e'(manual_code));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= SPD_NORMAL;
         valid_q  <= 1'b0;
         deemph_q <= 1'b0;
      end else begin
         mode_q   <= nxt_mode;
         valid_q  <= nxt_valid;
         deemph_q <= deemph_req && (nxt_mode == SPD_NORMAL);
      end
   end

   assign speed_mode = mode_q;
   assign mode_valid = valid_q;
   assign deemph_en  = deemph_q;
endmodule

// File: rtl/rate_mode_detect_chk.sv
`timescale 1ns/1ps
module rate_mode_detect_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       auto_sel,
   input logic [1:0] manual_code,
   input logic [1:0] speed_mode,
   input logic       mode_valid,
   input logic       deemph_en,
   input logic       stall_i
);
   assert_deemph_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      deemph_en |-> (speed_mode == 2'b00));

   assert_manual_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_sel && manual_code != 2'b11) |=> (speed_mode == $past(manual_code)));

   assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_sel && manual_code == 2'b11) |=> (!mode_valid && $stable(speed_mode)));

   assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      speed_mode != 2'b11);

   assert_stall_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> ##2 !mode_valid);
endmodule

bind rate_mode_detect rate_mode_detect_chk u_chk (
   .clk(clk), .rst_n(rst_n), .auto_sel(auto_sel), .manual_code(manual_code),
   .speed_mode(speed_mode), .mode_valid(mode_valid), .deemph_en(deemph_en),
   .stall_i(stall)
);

// File: tb/tb_rate_mode_detect.sv
`timescale 1ns/1ps
module tb_rate_mode_detect;
   localparam int TOL = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lrck = 1'b0;
   logic       auto_sel = 1'b1;
   logic [1:0] manual_code = 2'b00;
   logic       deemph_req = 1'b0;
   logic [1:0] speed_mode;
   logic       mode_valid;
   logic       deemph_en;

   rate_mode_detect dut (
      .clk(clk), .rst_n(rst_n), .lrck(lrck), .auto_sel(auto_sel),
      .manual_code(manual_code), .deemph_req(deemph_req),
      .speed_mode(speed_mode), .mode_valid(mode_valid), .deemph_en(deemph_en)
   );

   always #2 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string cur_req = "R1";
   int    blank = 4;

   // behavioural reference state
   int    per_q[$];
   int    prev_len = 0;
   int    m_last = 3;
   bit    m_ok = 0;
   int    m_mode = 0;
   int    held = 0;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int classify(input int p);
      int noms[6] = '{128, 192, 256, 384, 512, 768};
      int cl[6]   = '{2, 2, 1, 1, 0, 0};
      for (int i = 0; i < 6; i++)
         if (p >= noms[i] - TOL && p <= noms[i] + TOL) return cl[i];
      return 3;
   endfunction

   task automatic push_period(input int p);
      int c;
      per_q.push_back(p);
      c = classify(p);
      if (c == 3) m_ok = 0;
      else if (c == m_last) begin m_ok = 1; m_mode = c; end
      else m_ok = 0;
      m_last = c;
   endtask

   // every-clock comparison against the model, blanked over pipeline latency
   always @(posedge clk) begin
      int em, ev, ed;
      #1;
      if (auto_sel) begin em = m_mode; ev = int'(m_ok); end
      else if (manual_code != 2'b11) begin
         em = int'(manual_code); ev = int'(m_ok && m_mode == int'(manual_code));
      end else begin em = held; ev = 0; end
      ed = int'(deemph_req && em == 0);
      if (rst_n && blank == 0 && !finished) begin
         check(int'(speed_mode) == em, cur_req, "model speed_mode", int'(speed_mode), em);
         check(int'(mode_valid) == ev, cur_req, "model mode_valid", int'(mode_valid), ev);
         check(int'(deemph_en) == ed, "R10", "model deemph_en", int'(deemph_en), ed);
      end
      if (rst_n) held = em;
      if (blank > 0) blank--;
   end

   task automatic lr_period(input int p);
      @(negedge clk);
      lrck = 1'b1;
      if (prev_len > 0) push_period(prev_len);
      if (blank < 8) blank = 8;
      repeat (p / 2 - 1) @(negedge clk);
      lrck = 1'b0;
      repeat (p - p / 2) @(negedge clk);
      prev_len = p;
   endtask

   task automatic run(input int p, input int n);
      for (int i = 0; i < n; i++) lr_period(p);
   endtask

   task automatic set_in(input bit a, input logic [1:0] code, input bit dem);
      @(negedge clk);
      auto_sel = a; manual_code = code; deemph_req = dem;
      if (blank < 2) blank = 2;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input int em, input int ev, input int ed);
      check(int'(speed_mode) == em, req, "speed_mode", int'(speed_mode), em);
      check(int'(mode_valid) == ev, req, "mode_valid", int'(mode_valid), ev);
      if (ed >= 0) check(int'(deemph_en) == ed, req, "deemph_en", int'(deemph_en), ed);
   endtask

   task automatic summary;
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      repeat (6) @(negedge clk);
      expect_out("R1", 0, 0, 0);           // R1 during reset
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      expect_out("R1", 0, 0, 0);           // R1 after release

      // R2 normal, with de-emphasis request
      cur_req = "R2";
      set_in(1, 2'b00, 1);
      lr_period(512);
      lr_period(512);
      expect_out("R6", 0, 0, 1);           // one closed period: not yet valid
      lr_period(512);
      expect_out("R2", 0, 1, 1);           // R10 de-emphasis honoured at normal
      run(768, 2);
      expect_out("R2", 0, 1, 1);

      // R3 double
      cur_req = "R3";
      lr_period(256);
      lr_period(256);
      expect_out("R6", 0, 0, 1);           // class changed: valid cleared, mode held
      lr_period(256);
      expect_out("R3", 1, 1, 0);           // R10 forced off at double
      run(384, 2);
      expect_out("R3", 1, 1, 0);

      // R4 quad
      cur_req = "R4";
      run(128, 3);
      expect_out("R4", 2, 1, 0);
      run(192, 2);
      expect_out("R4", 2, 1, 0);

      // R5 tolerance edges
      cur_req = "R5";
      run(128 + TOL, 2);
      expect_out("R5", 2, 1, 0);
      run(128 + TOL + 1, 2);
      expect_out("R5", 2, 0, 0);           // outside window: invalid, mode held
      run(512 - TOL, 3);
      expect_out("R5", 0, 1, 1);

      // R7 / R9 manual
      cur_req = "R7";
      set_in(0, 2'b00, 1);
      expect_out("R7", 0, 1, 1);
      cur_req = "R9";
      set_in(0, 2'b01, 1);
      expect_out("R9", 1, 0, 0);           // manual double vs measured normal
      cur_req = "R7";
      set_in(0, 2'b10, 1);
      run(128, 3);
      expect_out("R7", 2, 1, 0);
      cur_req = "R8";
      set_in(0, 2'b11, 1);
      expect_out("R8", 2, 0, 0);
      lr_period(128);
      expect_out("R8", 2, 0, 0);

      // R7 manual code ignored in auto mode
      cur_req = "R7";
      set_in(1, 2'b10, 1);
      run(256, 3);
      expect_out("R7", 1, 1, 0);
      set_in(1, 2'b11, 1);
      lr_period(256);
      expect_out("R7", 1, 1, 0);

      // R11 stall and recovery
      cur_req = "R11";
      set_in(1, 2'b00, 0);
      run(512, 3);
      expect_out("R11", 0, 1, 0);
      @(negedge clk);
      lrck = 1'b1;
      push_period(prev_len);
      blank = 2300;
      m_ok = 0; m_last = 3;
      repeat (2199) @(negedge clk);
      expect_out("R11", 0, 0, 0);
      lrck = 1'b0;
      repeat (100) @(negedge clk);
      prev_len = 2300;
      blank = 0;
      lr_period(512);
      lr_period(512);
      expect_out("R11", 0, 0, 0);
      lr_period(512);
      expect_out("R11", 0, 1, 0);

      repeat (10) @(negedge clk);
      summary();
   end
endmodule